// File: doc/BRIEF.md
# Bus-Mapped Asynchronous Serial Port

This block puts an asynchronous serial link onto an 8-bit host register bus. The link runs 1 start bit, 8 data bits sent least significant bit first, and 1 stop bit. It has no parity. The host sees three registers, selected by a 2-bit offset:

| Offset | Register |
|---|---|
| 1 | Bit-period divisor |
| 2 | Data port |
| 3 | Status |

Writing the divisor register sets how many clock cycles one serial bit lasts. The same write also restarts the whole port.

On the send side, a single holding byte feeds a shift register. Software can queue the next byte while the current one is still on the wire, so consecutive frames leave with no idle gap between them. On the receive side, a circular store holds the incoming bytes. Sticky flags record framing errors and bytes that were lost because the store was full.

Typical divisor settings derive from the host clock. For a clock near 1.79 MHz the values are about 186 for 9600 baud, 93 for 19200 baud and 15 for 115200 baud. The host reads bytes from the data offset, queues bytes to the data offset, and clears the error flags by writing the status offset.

Top module: `ser_port_mm`

## Requirements
- R1: After reset the status reads 0x00, `ser_tx` idles high, and the divisor reads back as `DEF_DIV` at offset 1. Offset 0 always reads 0x00.
- R2: A write to offset 1 does all of the following at the next clock edge: loads the divisor, drives `ser_tx` high (aborting any frame in progress), empties the holding byte and the receive store, and clears every status bit.
- R3: A sent frame is a low start bit, then 8 data bits least significant bit first, then a high stop bit. Each bit lasts exactly divisor clock cycles.
- R4: Status bit 6 is set while the holding byte is occupied. A data write made while bit 6 is set is dropped and sets status bit 5. The byte already held is still sent.
- R5: When a byte is waiting in the holding buffer as a frame ends, its start bit begins in the clock cycle right after the previous stop bit. Successive start bits are therefore exactly 10 bit periods apart.
- R6: The receiver passes the input through a two-flop synchroniser. It confirms the start bit half a bit period after the falling edge, then samples each data bit at its middle. Status bit 7 is set while at least one byte is stored. A read of offset 2 returns the oldest byte and removes it. A read of offset 2 when the store is empty returns 0x00.
- R7: When a byte arrives while all DEPTH entries (16 by default) are occupied, that byte is discarded, the stored bytes are kept unchanged, and status bit 4 is set.
- R8: A stop bit sampled low sets status bit 3. The byte is stored anyway. The receiver does not look for a new start bit until the line has returned high.
- R9: A write of any value to offset 3 clears status bits 5:3 and leaves bits 7:6 unchanged. Status bits 2:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; it removes a byte only when `reg_sel` is 2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_sel` |
| ser_rx | input | 1 | Serial receive line, asynchronous |
| ser_tx | output | 1 | Serial transmit line |

## Verification
Register reads are combinational, so the bench drives the offset at a falling edge and samples `reg_rdata` shortly after. Every write or pop acts at the next rising edge, and the bench checks its effect at the falling edge after that.

A queued byte's start bit appears one edge after the write. The bench finds each start bit at the first falling edge where the line is low, then samples at the middle of each bit by counting whole bit periods. For the back-to-back case it checks that two consecutive frames start exactly ten bit periods apart.

A received byte reaches the store about three cycles after the middle of its stop bit, counting the synchroniser and receiver registers. The bench therefore reads status and data only after the full stop bit plus idle cycles have elapsed.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_BREAK = 3'd4
   } rx_state_e;

   localparam int unsigned FRAME_BITS = 10;
   localparam logic [1:0] SEL_DIV  = 2'd1;
   localparam logic [1:0] SEL_DATA = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/ser_rx_store.sv
module ser_rx_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("ser_rx_store: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [PTR_W:0] wp, rp, level;

   assign level = wp - rp;
   assign empty = (wp == rp);
   assign full  = (level == DEPTH[PTR_W:0]);
   assign head  = mem[rp[PTR_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en && !full)  wp <= wp + 1'b1;
         if (rd_en && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full && !flush) mem[wp[PTR_W-1:0]] <= wr_data;
   end

   AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH[PTR_W:0]); // R7
   AST_FULL_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en && !flush) |=> (full && $stable(head))); // R7
endmodule

// File: rtl/ser_tx_unit.sv
module ser_tx_unit #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic [DIV_W-1:0] div,
   input  logic             ld,
   input  logic [7:0]       ld_data,
   output logic             hold_full,
   output logic             tx_line
);
   localparam logic [3:0] LAST_BIT = 4'(ser_port_pkg::FRAME_BITS - 1);

   logic             hold_v;
   logic [7:0]       hold_d;
   logic             busy;
   logic [9:0]       sh;
   logic [3:0]       bitn;
   logic [DIV_W-1:0] tmr;
   logic             bit_end, frame_end, take;

   assign bit_end   = busy && (tmr == div - 1'b1);
   assign frame_end = bit_end && (bitn == LAST_BIT);
   assign take      = hold_v && (!busy || frame_end);
   assign hold_full = hold_v;
   assign tx_line   = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         bitn <= '0;
         tmr  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         sh   <= '1;
         bitn <= '0;
         tmr  <= '0;
      end else if (take) begin
         busy <= 1'b1;
         sh   <= {1'b1, hold_d, 1'b0};
         bitn <= '0;
         tmr  <= '0;
      end else if (busy) begin
         if (bit_end) begin
            tmr <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (frame_end) busy <= 1'b0;
            else           bitn <= bitn + 1'b1;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else if (abort) begin
         hold_v <= 1'b0;
      end else if (ld && !hold_v) begin
         hold_v <= 1'b1;
         hold_d <= ld_data;
      end else if (take) begin
         hold_v <= 1'b0;
      end
   end

   AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (tx_line && !hold_full)); // R2
   AST_DROP_KEEPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && hold_v && !abort) |=> $stable(hold_d)); // R4
endmodule

// File: rtl/ser_rx_unit.sv
module ser_rx_unit #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic [DIV_W-1:0] div,
   input  logic             line_in,
   output logic             push,
   output logic [7:0]       push_data,
   output logic             push_bad
);
   import ser_port_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ser_rx_unit: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync[0] <= 1'b1;
      else        sync[0] <= line_in;
   end
   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync[i] <= 1'b1;
         else        sync[i] <= sync[i-1];
      end
   end

   logic             rxs;
   logic [DIV_W-1:0] half, tmr;
   logic [2:0]       bitn;
   logic [7:0]       sh;
   rx_state_e        st;

   assign rxs  = sync[SYNC_STAGES-1];
   assign half = div >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         tmr       <= '0;
         bitn      <= '0;
         sh        <= '0;
         push      <= 1'b0;
         push_data <= '0;
         push_bad  <= 1'b0;
      end else if (abort) begin
         st   <= RX_IDLE;
         tmr  <= '0;
         push <= 1'b0;
      end else begin
         push <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               tmr <= '0;
               if (!rxs) st <= RX_START;
            end
            RX_START: begin
               if (tmr == half - 1'b1) begin
                  tmr  <= '0;
                  bitn <= '0;
                  st   <= rxs ? RX_IDLE : RX_DATA;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            RX_DATA: begin
               if (tmr == div - 1'b1) begin
                  tmr <= '0;
                  sh  <= {rxs, sh[7:1]};
                  if (bitn == 3'd7) st <= RX_STOP;
                  else              bitn <= bitn + 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            RX_STOP: begin
               if (tmr == div - 1'b1) begin
                  tmr       <= '0;
                  push      <= 1'b1;
                  push_data <= sh;
                  push_bad  <= !rxs;
                  st        <= rxs ? RX_IDLE : RX_BREAK;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            RX_BREAK: begin
               if (rxs) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push); // R6
   AST_BREAK_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_bad && !abort) |=> !push); // R8
endmodule

// File: rtl/ser_port_mm.sv
module ser_port_mm #(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned DEF_DIV     = 186,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       ser_rx,
   output logic       ser_tx
);
   import ser_port_pkg::*;

   if (DIV_W < 3 || DIV_W > 8) begin : g_bad_divw
      $error("ser_port_mm: DIV_W must lie in 3..8 to fit the data bus");
   end
   if (DEF_DIV < 4 || DEF_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("ser_port_mm: DEF_DIV must be at least 4 and fit DIV_W");
   end

   logic [DIV_W-1:0] div;
   logic baud_wr, data_wr, stat_wr, pop;
   logic tx_full, rx_push, rx_bad, st_empty, st_full;
   logic [7:0] rx_byte, st_head, status;
   logic f_frame, f_rxov, f_txov;

   assign baud_wr = reg_wr && (reg_sel == SEL_DIV);
   assign data_wr = reg_wr && (reg_sel == SEL_DATA);
   assign stat_wr = reg_wr && (reg_sel == SEL_STAT);
   assign pop     = reg_rd && (reg_sel == SEL_DATA) && !baud_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div <= DIV_W'(DEF_DIV);
      else if (baud_wr) div <= reg_wdata[DIV_W-1:0];
   end

   ser_tx_unit #(.DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .abort(baud_wr), .div(div),
      .ld(data_wr), .ld_data(reg_wdata),
      .hold_full(tx_full), .tx_line(ser_tx)
   );

   ser_rx_unit #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .abort(baud_wr), .div(div),
      .line_in(ser_rx), .push(rx_push), .push_data(rx_byte),
      .push_bad(rx_bad)
   );

   ser_rx_store #(.DEPTH(DEPTH), .W(8)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(baud_wr),
      .wr_en(rx_push), .wr_data(rx_byte), .rd_en(pop),
      .head(st_head), .empty(st_empty), .full(st_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_frame <= 1'b0;
         f_rxov  <= 1'b0;
         f_txov  <= 1'b0;
      end else if (baud_wr) begin
         f_frame <= 1'b0;
         f_rxov  <= 1'b0;
         f_txov  <= 1'b0;
      end else begin
         if (stat_wr) begin
            f_frame <= 1'b0;
            f_rxov  <= 1'b0;
            f_txov  <= 1'b0;
         end
         if (rx_push && rx_bad)   f_frame <= 1'b1;
         if (rx_push && st_full)  f_rxov  <= 1'b1;
         if (data_wr && tx_full)  f_txov  <= 1'b1;
      end
   end

   assign status = {!st_empty, tx_full, f_txov, f_rxov, f_frame, 3'b000};

   always_comb begin
      unique case (reg_sel)
         SEL_DIV:  reg_rdata = 8'(div);
         SEL_DATA: reg_rdata = st_empty ? 8'h00 : st_head;
         SEL_STAT: reg_rdata = status;
         default:  reg_rdata = 8'h00;
      endcase
   end

   AST_TXOV_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_full) |=> f_txov); // R4
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      baud_wr |=> (status == 8'h00 && ser_tx)); // R2
   AST_CLEAR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !rx_push && !pop) |=> $stable(status[7])); // R9
   AST_RXOV_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && st_full && !baud_wr) |=> f_rxov); // R7
endmodule

// File: tb/sim_ser_port_mm.sv
module sim_ser_port_mm;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic ser_rx = 1'b1;
   logic ser_tx;
   int nvec = 0, nbad = 0, cyc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ser_port_mm u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ser_rx(ser_rx), .ser_tx(ser_tx)
   );

   task automatic check(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_sel = a;
      #1 v = reg_rdata;
   endtask

   task automatic pop(output logic [7:0] v);
      @(negedge clk);
      reg_sel = 2'd2; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] d, input logic stopv, input int div);
      @(negedge clk);
      ser_rx = 1'b0;
      repeat (div) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         ser_rx = d[k];
         repeat (div) @(negedge clk);
      end
      ser_rx = stopv;
      repeat (div) @(negedge clk);
      ser_rx = 1'b1;
      repeat (div) @(negedge clk);
   endtask

   task automatic tx_capture(input int div, output logic [7:0] d,
                             output logic stopb, output int st);
      while (ser_tx !== 1'b0) @(negedge clk);
      st = cyc;
      repeat (div / 2) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         repeat (div) @(negedge clk);
         d[k] = ser_tx;
      end
      repeat (div) @(negedge clk);
      stopb = ser_tx;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nvec++; nbad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d0, d1;
      logic sb0, sb1;
      int s0, s1, div;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      peek(2'd3, v); check("R1 status", v, 8'h00);
      peek(2'd1, v); check("R1 divisor", v, 186);
      peek(2'd0, v); check("R1 offset0", v, 8'h00);
      check("R1 tx idle", ser_tx, 1);

      div = 8;
      bus_wr(2'd1, 8'(div));
      peek(2'd1, v); check("R2 divisor load", v, div);

      // R6 receive sweep over all byte values
      for (int b = 0; b < 256; b++) begin
         rx_send(8'(b), 1'b1, div);
         peek(2'd3, v); check("R6 ready", v, 8'h80);
         pop(v); check("R6 data", v, b);
      end
      peek(2'd3, v); check("R6 empty status", v, 8'h00);
      pop(v); check("R6 empty read", v, 8'h00);

      // R7 overflow keeps oldest sixteen
      for (int i = 0; i < 17; i++) rx_send(8'(8'h40 + i), 1'b1, div);
      peek(2'd3, v); check("R7 status", v, 8'h90);
      for (int i = 0; i < 16; i++) begin
         pop(v); check("R7 kept data", v, 8'h40 + i);
      end
      peek(2'd3, v); check("R7 sticky after drain", v, 8'h10);
      bus_wr(2'd3, 8'hFF);
      peek(2'd3, v); check("R9 clear", v, 8'h00);

      // R8 frame error, byte kept; R9 clear keeps ready
      rx_send(8'hA5, 1'b0, div);
      repeat (4) @(negedge clk);
      peek(2'd3, v); check("R8 ferr status", v, 8'h88);
      bus_wr(2'd3, 8'h00);
      peek(2'd3, v); check("R9 ready kept", v, 8'h80);
      pop(v); check("R8 byte stored", v, 8'hA5);
      rx_send(8'h3C, 1'b1, div);
      pop(v); check("R8 next byte clean", v, 8'h3C);

      // R3 transmit sweep at two divisors
      for (int i = 0; i < 16; i++) begin
         v = 8'(i * 37 + 11);
         fork
            tx_capture(div, d0, sb0, s0);
            bus_wr(2'd2, v);
         join
         check("R3 tx data", d0, v);
         check("R3 tx stop", sb0, 1);
      end
      div = 12;
      bus_wr(2'd1, 8'(div));
      for (int i = 0; i < 4; i++) begin
         v = 8'(8'hC3 ^ (i * 17));
         fork
            tx_capture(div, d0, sb0, s0);
            bus_wr(2'd2, v);
         join
         check("R3 tx data div12", d0, v);
         check("R3 tx stop div12", sb0, 1);
      end

      // R4 and R5: two queued, third dropped, frames back to back
      div = 8;
      bus_wr(2'd1, 8'(div));
      fork
         begin
            tx_capture(div, d0, sb0, s0);
            tx_capture(div, d1, sb1, s1);
         end
         begin
            bus_wr(2'd2, 8'h5A);
            repeat (3) @(negedge clk);
            bus_wr(2'd2, 8'hC7);
            bus_wr(2'd2, 8'h99);
            peek(2'd3, v); check("R4 full and txov", v, 8'h60);
         end
      join
      check("R4 first", d0, 8'h5A);
      check("R4 held byte sent", d1, 8'hC7);
      check("R5 spacing", s1 - s0, 10 * div);
      begin
         int hi = 1;
         for (int k = 0; k < 15 * div; k++) begin
            @(negedge clk);
            if (ser_tx !== 1'b1) hi = 0;
         end
         check("R4 dropped byte not sent", hi, 1);
      end
      peek(2'd3, v); check("R4 txov sticky", v, 8'h20);

      // R2 abort mid-frame flushes everything
      rx_send(8'h11, 1'b1, div);
      bus_wr(2'd2, 8'h00);
      repeat (30) @(negedge clk);
      bus_wr(2'd2, 8'hFF);
      peek(2'd3, v); check("R2 before", v, 8'hE0);
      bus_wr(2'd1, 8'(div));
      check("R2 tx high", ser_tx, 1);
      peek(2'd3, v); check("R2 status cleared", v, 8'h00);
      begin
         int hi = 1;
         for (int k = 0; k < 12 * div; k++) begin
            @(negedge clk);
            if (ser_tx !== 1'b1) hi = 0;
         end
         check("R2 no resend", hi, 1);
      end
      pop(v); check("R2 store flushed", v, 8'h00);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule